// File: doc/BRIEF.md
# Parallel Flash Strobe Timing Generator

This block drives the control strobes of an 8-bit parallel flash device: chip enable, command latch, address latch, write enable and read enable. It also drives the data bus direction. A request port with a valid/ready handshake hands it one byte operation at a time: a command byte, an address byte, a data write, a data read, or a wait for the device to leave its busy state. Every read returns its byte with a one-cycle completion pulse, and the other operations give the same pulse when they finish.

All phase lengths are taken from one packed 32-bit timing word, counted in system clock cycles. The word holds separate low and high times for the write and read strobes, a chip-enable setup delay, a bus turnaround delay and a busy-sample delay. Software normally programs each field to the clock ratio times the wanted time, plus one. The block does not latch the timing word, so it must not change while an operation is in progress. Chip enable runs in its normal mode: it is released whenever no operation is in progress, so it goes high for at least one cycle between two byte operations.

Top module: `flash_strobe_gen`

## Requirements
- R1: After reset, chip enable, write enable and read enable are high (inactive), command latch, address latch and data drive are low, `reqReady` is high and `rspValid` is low.
- R2: Chip enable is low for the whole of every byte operation and high in the completion cycle. Before the first strobe edge it stays low for exactly the number of cycles in timing bits 25:24 (0 means none).
- R3: For command, address and write operations, write enable stays low for timing bits 3:0 cycles and then high for bits 7:4 cycles before completion. A field value of 0 counts as 1.
- R4: For a read, read enable stays low for timing bits 11:8 cycles and then high for bits 15:12 cycles (0 counts as 1). The data bus is sampled in the last low cycle, and the byte appears on `rspData` together with `rspValid`.
- R5: If the previous byte operation was a command, address or write, a read first inserts timing bits 18:16 cycles of turnaround, with chip enable low and no strobe. Two reads in a row, or a read that is the first byte operation after reset, insert none.
- R6: Request kinds are encoded 0 = command, 1 = address, 2 = data write, 3 = data read, 4 = wait-ready. A command drives only the command latch high, an address drives only the address latch high, and data operations drive neither.
- R7: The data bus is driven with the request byte during command, address and write operations only. It is never driven during a read or during turnaround.
- R8: A wait-ready operation keeps chip enable high. It ignores the ready/busy input for timing bits 23:19 cycles, then waits for that input to be high, and pulses `rspValid` in the following cycle.
- R9: `reqReady` is high only when no operation is in progress, and `rspValid` is a single-cycle pulse at the end of each operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| timingWord | input | 32 | Packed phase lengths in clock cycles |
| reqValid | input | 1 | Request offered |
| reqKind | input | 3 | Operation kind (see R6) |
| reqData | input | 8 | Byte to drive for command/address/write |
| reqReady | output | 1 | Request accepted when high with reqValid |
| rspValid | output | 1 | Operation complete pulse |
| rspData | output | 8 | Byte captured by the last read |
| flashCeN | output | 1 | Chip enable, active low |
| flashCle | output | 1 | Command latch enable |
| flashAle | output | 1 | Address latch enable |
| flashWeN | output | 1 | Write enable, active low |
| flashReN | output | 1 | Read enable, active low |
| flashDqOut | output | 8 | Data bus output value |
| flashDqOe | output | 1 | Data bus output enable |
| flashDqIn | input | 8 | Data bus input value |
| flashRb | input | 1 | Ready/busy, high when ready |

## Verification
The bench measures each phase at the pins and compares its length with the timing fields. It covers zero fields, which must last one cycle; a design that took 0 literally would skip the strobe or wrap its counter through 16 or more cycles. It also covers all-ones fields, where a narrow counter would truncate. Turnaround is checked on write-then-read, on read-then-read and on the first read after reset, so a design that always or never inserts it is caught. The wait operation is checked with ready arriving before, during and long after the busy delay, and with zero and maximum delays; a design that samples ready too early finishes early.

// File: rtl/flash_strobe_pkg.sv
package flash_strobe_pkg;

  localparam int TIMING_W  = 32;
  localparam int STROBE_FW = 4;
  localparam int TURN_FW   = 3;
  localparam int BUSY_FW   = 5;
  localparam int CESET_FW  = 2;

  localparam int WRLOW_LSB  = 0;
  localparam int WRHIGH_LSB = 4;
  localparam int RDLOW_LSB  = 8;
  localparam int RDHIGH_LSB = 12;
  localparam int TURN_LSB   = 16;
  localparam int BUSY_LSB   = 19;
  localparam int CESET_LSB  = 24;

  typedef enum logic [2:0] {
    OP_CMD   = 3'd0,
    OP_ADDR  = 3'd1,
    OP_WRITE = 3'd2,
    OP_READ  = 3'd3,
    OP_WAIT  = 3'd4
  } opKind_t;

  typedef struct packed {
    logic [CESET_FW-1:0]  ceSetup;
    logic [BUSY_FW-1:0]   busyDly;
    logic [TURN_FW-1:0]   turn;
    logic [STROBE_FW-1:0] rdHigh;
    logic [STROBE_FW-1:0] rdLow;
    logic [STROBE_FW-1:0] wrHigh;
    logic [STROBE_FW-1:0] wrLow;
  } timing_t;

  typedef struct packed {
    logic ceLow;
    logic cleOn;
    logic aleOn;
    logic weLow;
    logic reLow;
    logic dqDrive;
    logic capture;
    logic take;
    logic done;
  } strobe_t;

endpackage

// File: rtl/flash_strobe_ctrl.sv
module flash_strobe_ctrl
  import flash_strobe_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  timing_t tf,
  input  logic    reqValid,
  input  logic [2:0] reqKind,
  input  logic    rbReady,
  output logic    reqReady,
  output strobe_t stb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_TURN, ST_LOW, ST_HIGH, ST_BUSY, ST_POLL
  } state_t;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  state_t            state, stateNxt;
  logic [CNT_W-1:0]  cnt, cntNxt;
  opKind_t           opQ;
  opKind_t           kSel;
  logic              lastWr;
  logic              doneQ;
  logic              cntZero;
  logic              needTurn;
  logic              kIsRead;
  logic [CNT_W-1:0]  lowLen, highLen, ceLen, turnLen, busyLen;
  logic              isWrOp;
  logic              inByteOp;

  assign kSel    = (state == ST_IDLE) ? opKind_t'(reqKind) : opQ;
  assign kIsRead = (kSel == OP_READ);
  assign cntZero = (cnt == '0);

  always_comb begin
    lowLen  = CNT_W'(kIsRead ? tf.rdLow  : tf.wrLow);
    highLen = CNT_W'(kIsRead ? tf.rdHigh : tf.wrHigh);
    if (lowLen == '0)  lowLen  = ONE;
    if (highLen == '0) highLen = ONE;
    ceLen   = CNT_W'(tf.ceSetup);
    turnLen = CNT_W'(tf.turn);
    busyLen = CNT_W'(tf.busyDly);
  end

  assign needTurn = lastWr && kIsRead && (turnLen != '0);

  always_comb begin
    stateNxt = state;
    cntNxt   = cntZero ? cnt : cnt - ONE;
    unique case (state)
      ST_IDLE: begin
        cntNxt = cnt;
        if (reqValid) begin
          if (kSel == OP_WAIT) begin
            if (busyLen != '0) begin
              stateNxt = ST_BUSY;
              cntNxt   = busyLen - ONE;
            end else begin
              stateNxt = ST_POLL;
            end
          end else if (ceLen != '0) begin
            stateNxt = ST_SETUP;
            cntNxt   = ceLen - ONE;
          end else if (needTurn) begin
            stateNxt = ST_TURN;
            cntNxt   = turnLen - ONE;
          end else begin
            stateNxt = ST_LOW;
            cntNxt   = lowLen - ONE;
          end
        end
      end
      ST_SETUP: if (cntZero) begin
        if (needTurn) begin
          stateNxt = ST_TURN;
          cntNxt   = turnLen - ONE;
        end else begin
          stateNxt = ST_LOW;
          cntNxt   = lowLen - ONE;
        end
      end
      ST_TURN: if (cntZero) begin
        stateNxt = ST_LOW;
        cntNxt   = lowLen - ONE;
      end
      ST_LOW: if (cntZero) begin
        stateNxt = ST_HIGH;
        cntNxt   = highLen - ONE;
      end
      ST_HIGH: if (cntZero) stateNxt = ST_IDLE;
      ST_BUSY: if (cntZero) stateNxt = ST_POLL;
      ST_POLL: if (rbReady) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      opQ    <= OP_CMD;
      lastWr <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      doneQ <= ((state == ST_HIGH) && cntZero) || ((state == ST_POLL) && rbReady);
      if (state == ST_IDLE && reqValid) opQ <= opKind_t'(reqKind);
      if (state == ST_HIGH && cntZero)  lastWr <= (opQ != OP_READ);
    end
  end

  assign isWrOp   = (opQ == OP_CMD) || (opQ == OP_ADDR) || (opQ == OP_WRITE);
  assign inByteOp = (state == ST_SETUP) || (state == ST_TURN) ||
                    (state == ST_LOW)   || (state == ST_HIGH);

  assign reqReady    = (state == ST_IDLE);
  assign stb.ceLow   = inByteOp;
  assign stb.cleOn   = inByteOp && (opQ == OP_CMD);
  assign stb.aleOn   = inByteOp && (opQ == OP_ADDR);
  assign stb.weLow   = (state == ST_LOW) && isWrOp;
  assign stb.reLow   = (state == ST_LOW) && (opQ == OP_READ);
  assign stb.dqDrive = inByteOp && isWrOp;
  assign stb.capture = (state == ST_LOW) && cntZero && (opQ == OP_READ);
  assign stb.take    = (state == ST_IDLE) && reqValid;
  assign stb.done    = doneQ;

  // R9: an accepted request makes the port busy on the next cycle
  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> !stb.done);

  // R8: while polling, a busy device keeps the operation open
  p_poll_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_POLL) && !rbReady) |=> (state == ST_POLL));

  // R8: the busy window never completes the operation
  p_busy_no_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |=> !stb.done);

endmodule

// File: rtl/flash_strobe_dp.sv
module flash_strobe_dp
  import flash_strobe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIMING_W-1:0] timingWord,
  input  logic [DATA_W-1:0] reqData,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] flashDqIn,
  output timing_t           tf,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              flashCeN,
  output logic              flashCle,
  output logic              flashAle,
  output logic              flashWeN,
  output logic              flashReN,
  output logic [DATA_W-1:0] flashDqOut,
  output logic              flashDqOe
);

  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] rdQ;

  assign tf.wrLow   = timingWord[WRLOW_LSB  +: STROBE_FW];
  assign tf.wrHigh  = timingWord[WRHIGH_LSB +: STROBE_FW];
  assign tf.rdLow   = timingWord[RDLOW_LSB  +: STROBE_FW];
  assign tf.rdHigh  = timingWord[RDHIGH_LSB +: STROBE_FW];
  assign tf.turn    = timingWord[TURN_LSB   +: TURN_FW];
  assign tf.busyDly = timingWord[BUSY_LSB   +: BUSY_FW];
  assign tf.ceSetup = timingWord[CESET_LSB  +: CESET_FW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      rdQ   <= '0;
    end else begin
      if (stb.take)    dataQ <= reqData;
      if (stb.capture) rdQ   <= flashDqIn;
    end
  end

  assign flashCeN   = ~stb.ceLow;
  assign flashCle   = stb.cleOn;
  assign flashAle   = stb.aleOn;
  assign flashWeN   = ~stb.weLow;
  assign flashReN   = ~stb.reLow;
  assign flashDqOe  = stb.dqDrive;
  assign flashDqOut = dataQ;
  assign rspValid   = stb.done;
  assign rspData    = rdQ;

  // R4: the two strobes are never low together
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashWeN && !flashReN));

  // R2: a strobe only moves while the device is selected
  p_ce_under_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN || !flashReN) |-> !flashCeN);

  // R7: the bus is released whenever read enable is low
  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    !flashReN |-> !flashDqOe);

  // R6: command and address latches are exclusive
  p_latch_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(flashCle && flashAle));

endmodule

// File: rtl/flash_strobe_gen.sv
module flash_strobe_gen
  import flash_strobe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       timingWord,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              flashCeN,
  output logic              flashCle,
  output logic              flashAle,
  output logic              flashWeN,
  output logic              flashReN,
  output logic [DATA_W-1:0] flashDqOut,
  output logic              flashDqOe,
  input  logic [DATA_W-1:0] flashDqIn,
  input  logic              flashRb
);

  timing_t tf;
  strobe_t stb;

  flash_strobe_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tf       (tf),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .rbReady  (flashRb),
    .reqReady (reqReady),
    .stb      (stb)
  );

  flash_strobe_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .timingWord (timingWord),
    .reqData    (reqData),
    .stb        (stb),
    .flashDqIn  (flashDqIn),
    .tf         (tf),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .flashCeN   (flashCeN),
    .flashCle   (flashCle),
    .flashAle   (flashAle),
    .flashWeN   (flashWeN),
    .flashReN   (flashReN),
    .flashDqOut (flashDqOut),
    .flashDqOe  (flashDqOe)
  );

endmodule

// File: tb/flash_strobe_gen_test.sv
module flash_strobe_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] timingWord = '0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = '0;
  logic [7:0]  reqData = '0;
  logic        reqReady, rspValid;
  logic [7:0]  rspData;
  logic        flashCeN, flashCle, flashAle, flashWeN, flashReN, flashDqOe;
  logic [7:0]  flashDqOut;
  logic [7:0]  flashDqIn = '0;
  logic        flashRb = 1'b1;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_strobe_gen uut (
    .clk(clk), .rstN(rstN), .timingWord(timingWord),
    .reqValid(reqValid), .reqKind(reqKind), .reqData(reqData),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .flashCeN(flashCeN), .flashCle(flashCle), .flashAle(flashAle),
    .flashWeN(flashWeN), .flashReN(flashReN), .flashDqOut(flashDqOut),
    .flashDqOe(flashDqOe), .flashDqIn(flashDqIn), .flashRb(flashRb)
  );

  function automatic logic [31:0] mkTw(int ce, int bd, int ta, int rh, int rl, int wh, int wl);
    return {6'd0, 2'(ce), 5'(bd), 3'(ta), 4'(rh), 4'(rl), 4'(wh), 4'(wl)};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(flashCeN == 1'b1, "R1", "ceN", flashCeN, 1);
    chk(flashWeN == 1'b1 && flashReN == 1'b1, "R1", "we/re", {flashWeN, flashReN}, 3);
    chk(!flashCle && !flashAle && !flashDqOe, "R1", "cle/ale/oe",
        {flashCle, flashAle, flashDqOe}, 0);
    chk(reqReady == 1'b1 && rspValid == 1'b0, "R1", "ready/valid", {reqReady, rspValid}, 2);
  endtask

  // Byte operation: measures pre-strobe, strobe-low and strobe-high lengths
  task automatic doOp(int kind, logic [7:0] data, logic [7:0] rdIn,
                      int expPre, int expLow, int expHigh, string req);
    int pre = 0, low = 0, high = 0, n = 0;
    bit sawCle = 0, sawAle = 0, sawOe = 0, oeBad = 0, ceLeak = 0, rdyLeak = 0;
    @(negedge clk);
    reqValid = 1'b1; reqKind = 3'(kind); reqData = data; flashDqIn = rdIn;
    chk(reqReady == 1'b1, "R9", "ready before op", reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid && n < 200) begin
      if (flashCeN) ceLeak = 1;
      if (reqReady) rdyLeak = 1;
      if (!flashWeN || !flashReN) low++;
      else if (low == 0) pre++;
      else high++;
      if (flashCle) sawCle = 1;
      if (flashAle) sawAle = 1;
      if (flashDqOe) begin
        sawOe = 1;
        if (flashDqOut != data) oeBad = 1;
      end
      @(negedge clk);
      n++;
    end
    chk(rspValid == 1'b1, "R9", {req, " completion"}, rspValid, 1);
    chk(!ceLeak, "R2", {req, " ce held low"}, ceLeak, 0);
    chk(flashCeN == 1'b1, "R2", {req, " ce released at end"}, flashCeN, 1);
    chk(!rdyLeak, "R9", {req, " ready low while busy"}, rdyLeak, 0);
    chk(pre == expPre, (kind == 3) ? "R5" : "R2", {req, " pre cycles"}, pre, expPre);
    chk(low == expLow, (kind == 3) ? "R4" : "R3", {req, " low cycles"}, low, expLow);
    chk(high == expHigh, (kind == 3) ? "R4" : "R3", {req, " high cycles"}, high, expHigh);
    chk(sawCle == (kind == 0), "R6", {req, " cle"}, sawCle, (kind == 0));
    chk(sawAle == (kind == 1), "R6", {req, " ale"}, sawAle, (kind == 1));
    chk(sawOe == (kind != 3), "R7", {req, " drive"}, sawOe, (kind != 3));
    chk(!oeBad, "R7", {req, " driven byte"}, flashDqOut, data);
    if (kind == 3) chk(rspData == rdIn, "R4", {req, " read byte"}, rspData, rdIn);
    @(negedge clk);
    chk(rspValid == 1'b0, "R9", {req, " pulse width"}, rspValid, 0);
  endtask

  // Wait-ready: rb released at negedge relAt (0 = already ready)
  task automatic doWait(int bd, int relAt);
    int n = 0, got = -1, expN;
    bit ceLeak = 0;
    timingWord = mkTw(1, bd, 2, 1, 1, 1, 1);
    flashRb = (relAt == 0);
    expN = (relAt > bd) ? relAt + 1 : bd + 2;
    @(negedge clk);
    reqValid = 1'b1; reqKind = 3'd4;
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    while (n < 100) begin
      if (rspValid) begin got = n; break; end
      if (!flashCeN) ceLeak = 1;
      if (n == relAt) flashRb = 1'b1;
      @(negedge clk);
      n++;
    end
    chk(got == expN, "R8", $sformatf("wait bd=%0d rel=%0d completion cycle", bd, relAt), got, expN);
    chk(!ceLeak, "R8", "wait keeps ce high", ceLeak, 0);
    flashRb = 1'b1;
  endtask

  task automatic testNominal();
    timingWord = mkTw(2, 5, 3, 1, 4, 2, 3);
    doOp(3, 8'h00, 8'hA5, 2, 4, 1, "first read no turn");
    doOp(0, 8'h30, 8'h00, 2, 3, 2, "command");
    doOp(1, 8'h5A, 8'h00, 2, 3, 2, "address");
    doOp(2, 8'hC3, 8'h00, 2, 3, 2, "write");
    doOp(3, 8'h00, 8'h96, 5, 4, 1, "read after write");
    doOp(3, 8'h00, 8'h69, 2, 4, 1, "read after read");
  endtask

  task automatic testZeroFields();
    timingWord = 32'd0;
    doOp(2, 8'h11, 8'h00, 0, 1, 1, "zero write");
    doOp(3, 8'h00, 8'h22, 0, 1, 1, "zero read");
  endtask

  task automatic testMaxFields();
    timingWord = mkTw(3, 31, 7, 15, 15, 15, 15);
    doOp(0, 8'hFF, 8'h00, 3, 15, 15, "max command");
    doOp(3, 8'h00, 8'h81, 10, 15, 15, "max read after command");
  endtask

  task automatic testWait();
    doWait(5, 9);
    doWait(5, 0);
    doWait(5, 3);
    doWait(0, 0);
    doWait(31, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testNominal();
    testZeroFields();
    testMaxFields();
    testWait();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule